// File: doc/BRIEF.md
# Segment access-rights check unit

This unit carries out the load-access-rights operation of a segmented protected-mode core. A request gives a 16-bit selector, the current privilege level, an operand-size flag, and the base and limit of the global and local descriptor tables. The unit finds the 8-byte descriptor and reads it as two 32-bit words through a simple request/ready memory port. It then tests the table limit, the descriptor type and the privilege.

When all tests pass, the unit returns the descriptor's attribute bits, masked to suit the operand size, together with a set zero flag and a write-enable for the destination register. When any test fails, the zero flag is clear and the destination is not written. A one-cycle completion pulse carries the outcome. Busy stays high for the whole operation.

Top module: `seg_rights_unit`

## Requirements
- R1: With `wide`=1, a passing `result` equals the high descriptor word (descriptor bits 63:32) ANDed with 32'h00F0FF00. This keeps granularity at bit 23, operand size at 22, bit 21, the available bit at 20, present at 15, DPL at 14:13, S at 12, type at 11:9 and accessed at 8.
- R2: With `wide`=0, a passing `result` holds descriptor bits 47:32 ANDed with 16'hFF00 in bits 15:0, and bits 31:16 are zero.
- R3: Selector bit 2 picks the local table (1) or the global table (0). Bits 15:3 are the index, and the descriptor byte offset is index*8. The test fails unless offset+7 <= the selected table's limit. The low word is read at base+offset and the high word at base+offset+4.
- R4: A global-table selector with index 0 fails, and no memory read is completed.
- R5: For S=0 (system or gate), only types 1-7, 9, B, C, E and F pass. Types 0, 8, A and D fail.
- R6: Every S=1 descriptor passes the type test. Conforming code (S=1, type bits 3 and 2 both set) skips the privilege test.
- R7: All other descriptors pass the privilege test only when max(`cpl`, selector bits 1:0) <= DPL.
- R8: On success, `zf`=1 and `wr_en`=1 during `done`. On failure, `zf`=0, `wr_en`=0 and `result`=0.
- R9: `busy` rises the cycle after an accepted `start` and stays high until `done` has pulsed for exactly one cycle. Each read holds `mem_req` and `mem_addr` steady until `mem_ready`.
- R10: A `start` seen while `busy` is ignored. The running operation finishes with its own result, and no further operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| sel | input | 16 | Selector to examine |
| cpl | input | 2 | Current privilege level |
| wide | input | 1 | 1: 32-bit operand, 0: 16-bit |
| gdt_base | input | AW | Global table base address |
| gdt_limit | input | AW | Global table limit |
| ldt_base | input | AW | Local table base address |
| ldt_limit | input | AW | Local table limit |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_ready | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Zero-flag outcome, valid with done |
| result | output | 32 | Masked attributes, valid with done |
| wr_en | output | 1 | Destination write-enable, valid with done |

## Verification
On every cycle the assertions enforce several properties. The completion pulse never lasts two cycles. A failed outcome carries a zero result. The attribute word never has bits set outside the mask. A narrow result has an empty upper half. A pending read keeps its address. A null global selector never raises a read. The bench scenarios cover the rest, because each needs a reference computation over the descriptor tables: whether each limit, type and privilege combination passes, the exact masked value, and which table and address are used. Those same scenarios also show that a start issued mid-operation is dropped.

// File: rtl/seg_rights_unit.sv
module seg_rights_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   sel,
  input  logic [1:0]    cpl,
  input  logic          wide,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] gdt_limit,
  input  logic [AW-1:0] ldt_base,
  input  logic [AW-1:0] ldt_limit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          zf,
  output logic [31:0]   result,
  output logic          wr_en
);
  localparam logic [15:0] SYS_OK = 16'hDAFE;
  localparam logic [31:0] MASK_W = 32'h00F0FF00;
  localparam logic [31:0] MASK_N = 32'h0000FF00;

  typedef enum logic [2:0] {S_IDLE, S_RLO, S_RHI, S_CHK, S_DONE} st_t;

  st_t           st;
  logic [15:0]   sel_q;
  logic [1:0]    cpl_q;
  logic          wide_q;
  logic          bad_q;
  logic [AW-1:0] ptr_q;
  logic [31:0]   hi_q;
  logic          zf_q;
  logic [31:0]   res_q;

  logic          ti;
  logic [AW-1:0] off;
  logic [AW:0]   last_byte;
  logic [AW:0]   lim_ext;
  logic          pre_bad;
  assign ti        = sel[2];
  assign off       = {{(AW-16){1'b0}}, sel[15:3], 3'b000};
  assign last_byte = {1'b0, off} + (AW+1)'(7);
  assign lim_ext   = {1'b0, ti ? ldt_limit : gdt_limit};
  assign pre_bad   = (!ti && sel[15:3] == 13'd0) || (last_byte > lim_ext);

  logic [3:0] dtype;
  logic       s_flag;
  logic [1:0] dpl;
  logic [1:0] eff_pl;
  logic       type_ok, priv_ok, pass;
  assign dtype   = hi_q[11:8];
  assign s_flag  = hi_q[12];
  assign dpl     = hi_q[14:13];
  assign eff_pl  = (cpl_q > sel_q[1:0]) ? cpl_q : sel_q[1:0];
  assign type_ok = s_flag || SYS_OK[dtype];
  assign priv_ok = (s_flag && dtype[3] && dtype[2]) || (eff_pl <= dpl);
  assign pass    = !bad_q && type_ok && priv_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_q  <= '0;
      cpl_q  <= '0;
      wide_q <= 1'b0;
      bad_q  <= 1'b0;
      ptr_q  <= '0;
      hi_q   <= '0;
      zf_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sel_q  <= sel;
          cpl_q  <= cpl;
          wide_q <= wide;
          bad_q  <= pre_bad;
          ptr_q  <= (ti ? ldt_base : gdt_base) + off;
          st     <= pre_bad ? S_CHK : S_RLO;
        end
        S_RLO: if (mem_ready) st <= S_RHI;
        S_RHI: if (mem_ready) begin
          hi_q <= mem_rdata;
          st   <= S_CHK;
        end
        S_CHK: begin
          zf_q  <= pass;
          res_q <= pass ? (hi_q & (wide_q ? MASK_W : MASK_N)) : 32'd0;
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_RLO) || (st == S_RHI);
  assign mem_addr = (st == S_RHI) ? ptr_q + AW'(4) : ptr_q;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign zf       = zf_q;
  assign result   = res_q;
  assign wr_en    = done && zf_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R8
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zf) |-> (result == 32'd0 && !wr_en));
  // R1
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result & ~MASK_W) == 32'd0));
  // R2
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (result[31:16] == 16'd0));
  // R4
  null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sel[2] && sel[15:3] == 13'd0) |=> !mem_req);
  // R10
  keep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

// File: tb/seg_rights_unit_test.sv
module seg_rights_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GB = 32'h0000_1000;
  localparam logic [31:0] LB = 32'h0002_0000;

  logic clk = 0, rst_n = 0, start = 0, wide = 0;
  logic [15:0] sel = '0;
  logic [1:0]  cpl = '0;
  logic [31:0] gdt_limit = 32'd255, ldt_limit = 32'd255;
  logic        mem_req, mem_ready = 0, busy, done, zf, wr_en;
  logic [31:0] mem_addr, mem_rdata = '0, result;

  logic [63:0] gtab [32];
  logic [63:0] ltab [32];
  int total = 0, bad = 0, cyc = 0, reads = 0, wait_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_rights_unit #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .cpl(cpl), .wide(wide),
    .gdt_base(GB), .gdt_limit(gdt_limit), .ldt_base(LB), .ldt_limit(ldt_limit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .zf(zf), .result(result), .wr_en(wr_en));

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [63:0] e;
    if (a >= GB && a < GB + 32'd256) e = gtab[(a - GB) >> 3];
    else if (a >= LB && a < LB + 32'd256) e = ltab[(a - LB) >> 3];
    else return 32'd0;
    return a[2] ? e[63:32] : e[31:0];
  endfunction

  function automatic logic [32:0] model(input logic [15:0] s, input logic [1:0] c, input logic w);
    logic [31:0] off, hi;
    logic [1:0] eff;
    logic ok;
    off = {16'd0, s[15:3], 3'b000};
    if (!s[2] && s[15:3] == 0) return 33'd0;
    if (off + 32'd7 > (s[2] ? ldt_limit : gdt_limit)) return 33'd0;
    hi = lookup((s[2] ? LB : GB) + off + 32'd4);
    eff = (c > s[1:0]) ? c : s[1:0];
    ok = hi[12] ? 1'b1 : !(hi[11:8] inside {4'h0, 4'h8, 4'hA, 4'hD});
    if (!(hi[12] && hi[11] && hi[10]) && eff > hi[14:13]) ok = 0;
    if (!ok) return 33'd0;
    return {1'b1, w ? (hi & 32'h00F0FF00) : {16'd0, hi[15:0] & 16'hFF00}};
  endfunction

  function automatic logic [63:0] mk(input logic s, input logic [3:0] t, input logic [1:0] d);
    return {8'hAB, 4'hF, 4'h5, 1'b1, d, s, t, 8'hCD, 32'h1234_5678};
  endfunction

  always @(negedge clk) begin
    if (mem_req && wait_n == 0) begin
      mem_ready <= 1; mem_rdata <= lookup(mem_addr); wait_n <= int'($urandom_range(0, 2));
    end else begin
      mem_ready <= 0;
      if (mem_req && wait_n > 0) wait_n <= wait_n - 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_req && mem_ready) reads <= reads + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [15:0] s, input logic [1:0] c, input logic w,
                    input string req, input logic extra_start);
    logic [32:0] e;
    int r0;
    e = model(s, c, w);
    r0 = reads;
    @(negedge clk); sel = s; cpl = c; wide = w; start = 1;
    @(negedge clk); start = 0;
    chk("R9 busy after start", {31'd0, busy}, 32'd1);
    if (extra_start) begin
      sel = ~s; cpl = 2'd0; wide = !w; start = 1;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk({req, " zf"}, {31'd0, zf}, {31'd0, e[32]});
    chk({req, " wr_en"}, {31'd0, wr_en}, {31'd0, e[32]});
    chk({req, " result"}, result, e[31:0]);
    @(negedge clk);
    chk("R9 done one cycle", {30'd0, done, busy}, 32'd0);
    if (!s[2] && s[15:3] == 0) chk("R4 no read", reads - r0, 32'd0);
    else if (e[32]) chk("R3 two reads", reads - r0, 32'd2);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      chk("R10 no second op", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      gtab[i] = {$urandom, $urandom};
      ltab[i] = {$urandom, $urandom};
    end
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R8 reset wr_en", {30'd0, wr_en, done}, 32'd0);
    chk("R9 reset req", {31'd0, mem_req}, 32'd0);
    rst_n = 1;

    gtab[1] = mk(1'b1, 4'h3, 2'd3);
    op(16'h0008, 2'd0, 1'b1, "R1 wide", 1'b0);
    op(16'h0008, 2'd0, 1'b0, "R2 narrow", 1'b0);
    op(16'h0000, 2'd0, 1'b1, "R4 null", 1'b0);
    op(16'h0003, 2'd0, 1'b1, "R4 null rpl", 1'b0);
    ltab[0] = mk(1'b1, 4'h2, 2'd3); ldt_limit = 32'd7;
    op(16'h0004, 2'd0, 1'b1, "R3 ldt index0", 1'b0);
    ldt_limit = 32'd6;
    op(16'h0004, 2'd0, 1'b1, "R3 limit short", 1'b0);
    gtab[5] = mk(1'b1, 4'h2, 2'd0); gdt_limit = 32'd47;
    op(16'h0028, 2'd0, 1'b1, "R3 limit edge", 1'b0);
    gdt_limit = 32'd46;
    op(16'h0028, 2'd0, 1'b1, "R3 limit over", 1'b0);
    gdt_limit = 32'd255; ldt_limit = 32'd255;
    for (int t = 0; t < 16; t++) begin
      gtab[2] = mk(1'b0, 4'(t), 2'd3);
      op(16'h0010, 2'd3, 1'b1, "R5 sys type", 1'b0);
    end
    gtab[3] = mk(1'b1, 4'hE, 2'd0);
    op(16'h001B, 2'd3, 1'b1, "R6 conforming", 1'b0);
    gtab[3] = mk(1'b1, 4'hA, 2'd0);
    op(16'h0018, 2'd3, 1'b1, "R7 cpl high", 1'b0);
    gtab[3] = mk(1'b1, 4'hA, 2'd2);
    op(16'h001B, 2'd0, 1'b1, "R7 rpl high", 1'b0);
    op(16'h001A, 2'd2, 1'b0, "R7 equal", 1'b0);
    op(16'h0008, 2'd0, 1'b1, "R10 ignored start", 1'b1);

    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        gdt_limit = 32'($urandom_range(0, 300));
        ldt_limit = 32'($urandom_range(0, 300));
      end
      op({13'($urandom_range(0, 40)), 1'($urandom), 2'($urandom)}, 2'($urandom),
         1'($urandom), "R8 random", 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule